// File: doc/BRIEF.md
# 3x3 Mean Image Filter

This block smooths a fixed 32 x 32 frame of unsigned 8-bit grayscale pixels. Software or a neighbouring engine first fills the internal input frame through a simple write port. A one-cycle start pulse then launches one pass over the frame. During the pass, every interior output pixel becomes the truncated average of the nine input pixels in the 3 x 3 square centred on it. The pixels on the outer ring have no complete neighbourhood and are written as zero.

The pass walks the frame row by row, and within a row column by column. It reads one input pixel per clock into two line buffers and a 3 x 3 window register, so that after the pipeline fills, one output pixel is written per clock. The scan runs one extra phantom column and one extra phantom row so that the window also reaches the last row and column; this lets every one of the 1024 output positions be written exactly once per pass.

A one-cycle done pulse ends the pass. After that, the filtered frame can be read back through a registered read port at any time. While a pass is running, further start pulses and pixel writes are ignored.

Top module: `mean3x3_filter`

## Requirements
- R1: After reset, busy and done are low and rdData is 0.
- R2: When loadEn is high and the block is idle, loadData is stored as the input pixel at row loadAddr[9:5], column loadAddr[4:0].
- R3: For every output pixel with row and column both in 1..30, the stored value is the sum of the nine input pixels at rows r-1..r+1 and columns c-1..c+1, divided by 9 and truncated.
- R4: Every output pixel in row 0, row 31, column 0 or column 31 is written as 0.
- R5: After a start pulse taken while idle, busy is high from the next cycle on. Done is high for exactly one cycle, 1091 clock edges after the edge that captured start ((W+1)(H+1)+2). Busy is low from that same cycle.
- R6: A start pulse while busy is ignored: it neither restarts nor lengthens the pass.
- R7: A pixel write while busy is ignored and does not alter the frame being filtered.
- R8: rdData shows the output pixel at rdAddr (same row/column bit layout as R2) one clock edge after rdAddr is presented, and holds its old value until that edge.
- R9: A frame of all 255 produces 255 at every interior output, so the nine-pixel sum never overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a filtering pass |
| loadEn | input | 1 | Input-frame write enable |
| loadAddr | input | 10 | Input pixel address, row in [9:5], column in [4:0] |
| loadData | input | 8 | Input pixel value |
| rdAddr | input | 10 | Output pixel address, row in [9:5], column in [4:0] |
| rdData | output | 8 | Output pixel value, one cycle after rdAddr |
| busy | output | 1 | High while a pass is in progress |
| done | output | 1 | One-cycle pulse when the pass has written its last pixel |

## Verification
The done pulse is due on the 1091st clock edge after the edge that captures start. The bench counts edges from that edge and compares the count exactly. It also checks that done has fallen, and busy with it, one cycle later. Read data is due one edge after the address is driven. The bench drives every input on a falling edge and samples on the next falling edge. One extra sample, taken just before the rising edge, confirms that the old value is still held. Full-frame expected images are computed in the bench arithmetically for a constant-maximum frame, a single bright pixel and a pseudo-random frame, and every output pixel is compared.

// File: rtl/mf_pkg.sv
package mf_pkg;
  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic readIn;     // fetch one input pixel this cycle
    logic shiftIn;    // fetched pixel enters line buffers and window
    logic padIn;      // fetched slot is a phantom position: shift zero
    logic writeOut;   // write one output pixel this cycle
    logic writeMean;  // output is interior: write mean, else zero
  } mfStrobe_t;
endpackage

// File: rtl/mf_ctrl.sv
module mf_ctrl #(
  parameter int IMG_W   = 32,
  parameter int IMG_H   = 32,
  parameter int ADDR_W  = 10,
  parameter int COORD_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output mf_pkg::mfStrobe_t    strobe,
  output logic [ADDR_W-1:0]    inAddr,
  output logic [ADDR_W-1:0]    outAddr
);
  localparam logic [COORD_W-1:0] COL_END  = COORD_W'(IMG_W);
  localparam logic [COORD_W-1:0] ROW_END  = COORD_W'(IMG_H);
  localparam logic [COORD_W-1:0] COL_LAST = COORD_W'(IMG_W - 1);
  localparam logic [COORD_W-1:0] ROW_LAST = COORD_W'(IMG_H - 1);

  logic               scanning;
  logic [COORD_W-1:0] rowCnt, colCnt;
  logic               v1, v2;
  logic [COORD_W-1:0] r1, c1, r2, c2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; scanning <= 1'b0;
      rowCnt <= '0; colCnt <= '0;
      v1 <= 1'b0; r1 <= '0; c1 <= '0;
      v2 <= 1'b0; r2 <= '0; c2 <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; scanning <= 1'b1;
        rowCnt <= '0; colCnt <= '0;
      end else if (scanning) begin
        if (colCnt == COL_END) begin
          colCnt <= '0;
          if (rowCnt == ROW_END) scanning <= 1'b0;
          else rowCnt <= rowCnt + 1'b1;
        end else begin
          colCnt <= colCnt + 1'b1;
        end
      end
      v1 <= scanning; r1 <= rowCnt; c1 <= colCnt;
      v2 <= v1;       r2 <= r1;     c2 <= c1;
      if (v2 && r2 == ROW_END && c2 == COL_END) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.readIn    = scanning && (rowCnt < ROW_END) && (colCnt < COL_END);
    strobe.shiftIn   = v1;
    strobe.padIn     = !((r1 < ROW_END) && (c1 < COL_END));
    strobe.writeOut  = v2 && (r2 != '0) && (c2 != '0);
    strobe.writeMean = v2 && (r2 >= 2) && (r2 <= ROW_LAST) &&
                       (c2 >= 2) && (c2 <= COL_LAST);
    inAddr  = ADDR_W'(int'(rowCnt) * IMG_W + int'(colCnt));
    outAddr = ADDR_W'((int'(r2) - 1) * IMG_W + int'(c2) - 1);
  end

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  assert_busy_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !(scanning && rowCnt == '0 && colCnt == '0));
endmodule

// File: rtl/mf_datapath.sv
module mf_datapath #(
  parameter int IMG_W  = 32,
  parameter int IMG_H  = 32,
  parameter int PIX_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mf_pkg::mfStrobe_t    strobe,
  input  logic [ADDR_W-1:0]    inAddr,
  input  logic [ADDR_W-1:0]    outAddr,
  input  logic                 loadWe,
  input  logic [ADDR_W-1:0]    loadAddr,
  input  logic [PIX_W-1:0]     loadData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [PIX_W-1:0]     rdData
);
  localparam int DEPTH    = IMG_W * IMG_H;
  localparam int LINE_LEN = IMG_W + 1;
  localparam int K        = 3;
  localparam int KN       = K * K;
  localparam int SUM_W    = PIX_W + $clog2(KN);

  logic [PIX_W-1:0] inMem  [DEPTH];
  logic [PIX_W-1:0] outMem [DEPTH];
  logic [PIX_W-1:0] pixQ, pixIn;
  logic [PIX_W-1:0] lineA [LINE_LEN];
  logic [PIX_W-1:0] lineB [LINE_LEN];
  logic [PIX_W-1:0] win   [K][K];
  logic [SUM_W-1:0] winSum;
  logic [PIX_W-1:0] meanVal;

  // Input frame: load port writes, scan reads (never in the same cycle).
  always_ff @(posedge clk) begin
    if (loadWe) inMem[loadAddr] <= loadData;
    if (strobe.readIn) pixQ <= inMem[inAddr];
  end

  assign pixIn = strobe.padIn ? '0 : pixQ;

  // Two row-delay lines feed the top and middle rows of the window.
  always_ff @(posedge clk) begin
    if (strobe.shiftIn) begin
      for (int i = 0; i < LINE_LEN - 1; i++) begin
        lineA[i] <= lineA[i+1];
        lineB[i] <= lineB[i+1];
      end
      lineA[LINE_LEN-1] <= pixIn;
      lineB[LINE_LEN-1] <= lineA[0];
      for (int r = 0; r < K; r++) begin
        for (int c = 0; c < K - 1; c++) win[r][c] <= win[r][c+1];
      end
      win[0][K-1] <= lineB[0];
      win[1][K-1] <= lineA[0];
      win[2][K-1] <= pixIn;
    end
  end

  always_comb begin
    winSum = '0;
    for (int r = 0; r < K; r++) begin
      for (int c = 0; c < K; c++) winSum = winSum + SUM_W'(win[r][c]);
    end
    meanVal = PIX_W'(winSum / SUM_W'(KN));
  end

  always_ff @(posedge clk) begin
    if (strobe.writeOut) outMem[outAddr] <= strobe.writeMean ? meanVal : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= outMem[rdAddr];
  end

  assert_mean_trunc_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMean |-> (int'(meanVal) * KN <= int'(winSum)) &&
                         (int'(winSum) < int'(meanVal) * KN + KN));
  assert_mean_in_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeMean |-> strobe.writeOut && int'(outAddr) < DEPTH);
  assert_load_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadWe |-> !strobe.readIn);
endmodule

// File: rtl/mean3x3_filter.sv
module mean3x3_filter #(
  parameter int IMG_W = 32,
  parameter int IMG_H = 32,
  parameter int PIX_W = 8,
  localparam int ADDR_W = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [PIX_W-1:0]  loadData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PIX_W-1:0]  rdData,
  output logic              busy,
  output logic              done
);
  localparam int COORD_W = $clog2((IMG_W > IMG_H ? IMG_W : IMG_H) + 1);

  mf_pkg::mfStrobe_t strobe;
  logic [ADDR_W-1:0] inAddr, outAddr;
  logic              loadWe;

  assign loadWe = loadEn && !busy;  // R7: frame is frozen during a pass

  mf_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W), .COORD_W(COORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .strobe(strobe), .inAddr(inAddr), .outAddr(outAddr)
  );

  mf_datapath #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr), .outAddr(outAddr),
    .loadWe(loadWe), .loadAddr(loadAddr), .loadData(loadData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_mean3x3_filter.sv
`timescale 1ns/1ps
module sim_mean3x3_filter;
  localparam int W = 32;
  localparam int H = 32;
  localparam int N = W * H;
  localparam int DONE_EDGES = (W + 1) * (H + 1) + 3; // edges incl. the start edge

  logic       clk = 1'b0;
  logic       rstN, start, loadEn;
  logic [9:0] loadAddr, rdAddr;
  logic [7:0] loadData, rdData;
  logic       busy, done;

  int  img [N];
  int  testCnt = 0;
  int  failCnt = 0;
  bit  finished = 0;

  always #2 clk = ~clk;

  mean3x3_filter u0 (
    .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .rdAddr(rdAddr),
    .rdData(rdData), .busy(busy), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expOut(input int a);
    int r, c, s;
    r = a / W; c = a % W; s = 0;
    if (r < 1 || r > H - 2 || c < 1 || c > W - 2) return 0;
    for (int dr = -1; dr <= 1; dr++)
      for (int dc = -1; dc <= 1; dc++)
        s += img[(r + dr) * W + c + dc];
    return s / 9;
  endfunction

  task automatic loadFrame();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 10'(i); loadData = 8'(img[i]);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic runFrame(input bit disturb);
    int cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 1;
    check("R5", "busy after start", int'(busy), 1);
    while (!done && cnt < 5000) begin
      if (disturb && cnt == 5) begin
        start = 1'b1; loadEn = 1'b1;
        loadAddr = 10'(30 * W + 30); loadData = ~8'(img[30 * W + 30]);
      end else begin
        start = 1'b0; loadEn = 1'b0;
      end
      @(negedge clk); cnt++;
    end
    check(disturb ? "R6" : "R5", "edges from start to done", cnt, DONE_EDGES);
    check("R5", "busy low with done", int'(busy), 0);
    @(negedge clk);
    check("R5", "done one cycle only", int'(done), 0);
  endtask

  task automatic readFrame(input string interiorTag);
    for (int a = 0; a < N; a++) begin
      @(negedge clk); rdAddr = 10'(a);
      @(negedge clk);
      if (expOut(a) == 0 && (a / W == 0 || a / W == H - 1 || a % W == 0 || a % W == W - 1))
        check("R4", $sformatf("border pixel %0d", a), int'(rdData), 0);
      else
        check(interiorTag, $sformatf("pixel %0d", a), int'(rdData), expOut(a));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    rstN = 1'b0; start = 1'b0; loadEn = 1'b0;
    loadAddr = '0; loadData = '0; rdAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "rdData after reset", int'(rdData), 0);

    // R9: all-maximum frame, no sum overflow
    for (int i = 0; i < N; i++) img[i] = 255;
    loadFrame();
    runFrame(1'b0);
    readFrame("R9");

    // R2: one bright pixel at row 5, column 9 locates the address layout
    for (int i = 0; i < N; i++) img[i] = 0;
    img[5 * W + 9] = 255;
    loadFrame();
    runFrame(1'b0);
    readFrame("R2");

    // R8: registered read latency
    @(negedge clk); rdAddr = 10'(0);
    @(negedge clk);
    check("R8", "read of pixel 0", int'(rdData), 0);
    rdAddr = 10'(5 * W + 9);
    #1;
    check("R8", "old data held before edge", int'(rdData), 0);
    @(negedge clk);
    check("R8", "read after one edge", int'(rdData), 28);

    // R3/R6/R7: pseudo-random frame, start and load pulsed mid-pass
    seed = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      img[i] = int'(seed[23:16]);
    end
    loadFrame();
    runFrame(1'b1);
    readFrame("R3");
    @(negedge clk); rdAddr = 10'(30 * W + 30);
    @(negedge clk);
    check("R7", "pixel near ignored write", int'(rdData), expOut(30 * W + 30));

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule